// File: doc/BRIEF.md
# Coprocessor Escape and Wait Gate

This block sits in a processor's issue path, in front of an attached numeric coprocessor. Each decoded instruction arrives as a one-cycle strobe carrying its first opcode byte and two flags. One flag marks the synchronising wait instruction. The other marks an escape that must look at the coprocessor's error line before it issues. The gate either forwards the escape to the coprocessor or raises an exception. Vector 7 means the coprocessor is unavailable and vector 16 means the coprocessor reported an error. For a wait instruction, the gate stalls the issue stage until the coprocessor releases its active-low busy line.

The gate also holds the four coprocessor control bits:
- EM: emulate.
- MP: monitor.
- TS: task switched.
- ET: extension type, which picks the 16- or 32-bit transfer protocol.

Only privilege level zero may write these bits or clear TS. A task switch always sets TS. The instruction checks use the control values held before any update made in the same cycle.

Top module: `cop_gate`

## Requirements
- R1: An instruction is an escape when bits [7:3] of its opcode byte equal 11011 and its wait flag is clear. A strobe that is neither an escape nor a wait produces no forward pulse and no exception.
- R2: An escape seen while EM is set raises exception vector 7 in the cycle after the strobe and is not forwarded, whatever the other bits hold.
- R3: An escape seen while EM is clear and TS is set raises vector 7 and is not forwarded, whatever the value of MP.
- R4: An escape with EM and TS clear, flagged as error-checking and seen while error_n is low, raises vector 16. An escape without that flag ignores error_n.
- R5: An escape with no exception condition drives cop_fwd high for exactly the one cycle after its strobe. exc_valid and cop_fwd are never high together.
- R6: A wait instruction tests TS only when MP is set. With both set it raises vector 7 in the next cycle without stalling. With MP clear, TS has no effect on it.
- R7: A wait instruction that does not fault drives stall high from the cycle after its strobe. Stall stays high while busy_n is sampled low. After the first edge that samples busy_n high, stall falls, and vector 16 is raised if error_n was low at that edge. Strobes that arrive while stall is high are ignored.
- R8: A write with cpl equal to 0 loads ctl_wdata into the control bits, which read back on ctl_q with bit 0 as EM, bit 1 as MP, bit 2 as TS and bit 3 as ET. task_switch sets TS. A privileged ts_clear clears TS. task_switch wins over a clear or a write in the same cycle.
- R9: A write or ts_clear with cpl not equal to 0 leaves ctl_q unchanged and pulses prot_fault for one cycle.
- R10: At reset, EM, MP and TS become 0 and ET takes the level of error_n during reset. proto32 always equals ET.
- R11: An instruction strobe is judged against the control bits as they stood before a write or task switch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decoded instruction strobe |
| instr_opcode | input | 8 | First opcode byte |
| instr_is_wait | input | 1 | Strobe is a wait instruction |
| instr_chk_err | input | 1 | Escape must test the error line |
| busy_n | input | 1 | Coprocessor busy, active low |
| error_n | input | 1 | Coprocessor error, active low |
| ctl_wr | input | 1 | Control bit write request |
| ctl_wdata | input | 4 | New control bits {ET,TS,MP,EM} |
| cpl | input | 2 | Current privilege level |
| task_switch | input | 1 | Task switch happened, sets TS |
| ts_clear | input | 1 | Privileged TS clear request |
| cop_fwd | output | 1 | Forward escape to coprocessor |
| stall | output | 1 | Hold issue while wait is pending |
| exc_valid | output | 1 | Exception pulse |
| exc_vector | output | 5 | Exception vector (7 or 16) |
| proto32 | output | 1 | 32-bit protocol select |
| prot_fault | output | 1 | Unprivileged control access |
| ctl_q | output | 4 | Control bits {ET,TS,MP,EM} |

## Verification
Two functions can act in the same cycle. An instruction strobe can arrive together with a control write, a task switch or a TS clear. The bench provokes this on purpose: it sends an escape in the cycle that a privileged write sets EM, or in the cycle a task switch sets TS. It expects the escape to be judged against the old bits, so it is forwarded. In the following cycle, ctl_q must show the new bits. Random mixes of operations are checked against a bench model of the control bits, and the same rule applies there.

// File: rtl/cop_gate_pkg.sv
package cop_gate_pkg;

   // Field order matches the control write data bits [3:0]
   typedef struct packed {
      logic et;
      logic ts;
      logic mp;
      logic em;
   } cop_ctl_t;

   typedef enum logic {
      W_IDLE = 1'b0,
      W_HOLD = 1'b1
   } wait_st_t;

endpackage

// File: rtl/cop_ctl_regs.sv
module cop_ctl_regs
   import cop_gate_pkg::*;
#(
   parameter int   PRIV_W       = 2,
   parameter bit   ET_FROM_PIN  = 1'b1,
   parameter logic ET_RESET_VAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              error_n,
   input  logic [PRIV_W-1:0] cpl,
   input  logic              wr_en,
   input  cop_ctl_t          wr_data,
   input  logic              task_switch,
   input  logic              ts_clear,
   output cop_ctl_t          ctl,
   output logic              prot_fault
);

   logic priv;
   logic et_rst;

   assign priv = (cpl == '0);

   generate
      if (ET_FROM_PIN) begin : g_et_pin
         assign et_rst = error_n;
      end else begin : g_et_fixed
         logic unused_err;
         assign unused_err = error_n;
         assign et_rst = ET_RESET_VAL;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl.em     <= 1'b0;
         ctl.mp     <= 1'b0;
         ctl.ts     <= 1'b0;
         ctl.et     <= et_rst;
         prot_fault <= 1'b0;
      end else begin
         prot_fault <= (wr_en | ts_clear) & ~priv;
         if (wr_en & priv)    ctl    <= wr_data;
         if (ts_clear & priv) ctl.ts <= 1'b0;
         if (task_switch)     ctl.ts <= 1'b1;
      end
   end

   AST_TS_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      task_switch |=> ctl.ts); // R8

   AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en | ts_clear) && !priv && !task_switch) |=> ($stable(ctl) && prot_fault)); // R9

endmodule

// File: rtl/cop_esc_check.sv
module cop_esc_check
   import cop_gate_pkg::*;
#(
   parameter int                  OPC_W    = 8,
   parameter int                  ESC_BITS = 5,
   parameter logic [ESC_BITS-1:0] ESC_CODE = 5'b11011,
   parameter int                  VEC_W    = 5,
   parameter int                  VEC_NA   = 7,
   parameter int                  VEC_ERR  = 16
) (
   input  logic [OPC_W-1:0] opcode,
   input  cop_ctl_t         ctl,
   input  logic             chk_err,
   input  logic             error_n,
   output logic             is_esc,
   output logic             raise,
   output logic [VEC_W-1:0] vec,
   output logic             fwd
);

   assign is_esc = (opcode[OPC_W-1 -: ESC_BITS] == ESC_CODE);

   // Fixed priority: emulation, then task switched, then pending error
   always_comb begin
      raise = 1'b0;
      vec   = VEC_W'(VEC_NA);
      fwd   = 1'b0;
      if (ctl.em) begin
         raise = 1'b1;
      end else if (ctl.ts) begin
         raise = 1'b1;
      end else if (chk_err && !error_n) begin
         raise = 1'b1;
         vec   = VEC_W'(VEC_ERR);
      end else begin
         fwd = 1'b1;
      end
   end

endmodule

// File: rtl/cop_wait_fsm.sv
module cop_wait_fsm
   import cop_gate_pkg::*;
#(
   parameter int VEC_W   = 5,
   parameter int VEC_NA  = 7,
   parameter int VEC_ERR = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  cop_ctl_t         ctl,
   input  logic             busy_n,
   input  logic             error_n,
   output logic             waiting,
   output logic             raise,
   output logic [VEC_W-1:0] vec
);

   wait_st_t st, st_nxt;

   always_comb begin
      st_nxt = st;
      raise  = 1'b0;
      vec    = VEC_W'(VEC_NA);
      case (st)
         W_IDLE: begin
            if (start) begin
               if (ctl.mp && ctl.ts) raise  = 1'b1;
               else                  st_nxt = W_HOLD;
            end
         end
         W_HOLD: begin
            if (busy_n) begin
               st_nxt = W_IDLE;
               if (!error_n) begin
                  raise = 1'b1;
                  vec   = VEC_W'(VEC_ERR);
               end
            end
         end
         default: st_nxt = W_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= W_IDLE;
      else        st <= st_nxt;
   end

   assign waiting = (st == W_HOLD);

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_HOLD && !busy_n) |=> (st == W_HOLD)); // R7

   AST_MP_TS_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_IDLE && start && ctl.mp && ctl.ts) |=> (st == W_IDLE)); // R6

endmodule

// File: rtl/cop_gate.sv
module cop_gate
   import cop_gate_pkg::*;
#(
   parameter int                  OPC_W        = 8,
   parameter int                  ESC_BITS     = 5,
   parameter logic [ESC_BITS-1:0] ESC_CODE     = 5'b11011,
   parameter int                  PRIV_W       = 2,
   parameter int                  VEC_W        = 5,
   parameter int                  VEC_NA       = 7,
   parameter int                  VEC_ERR      = 16,
   parameter bit                  ET_FROM_PIN  = 1'b1,
   parameter logic                ET_RESET_VAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [OPC_W-1:0]  instr_opcode,
   input  logic              instr_is_wait,
   input  logic              instr_chk_err,
   input  logic              busy_n,
   input  logic              error_n,
   input  logic              ctl_wr,
   input  logic [3:0]        ctl_wdata,
   input  logic [PRIV_W-1:0] cpl,
   input  logic              task_switch,
   input  logic              ts_clear,
   output logic              cop_fwd,
   output logic              stall,
   output logic              exc_valid,
   output logic [VEC_W-1:0]  exc_vector,
   output logic              proto32,
   output logic              prot_fault,
   output logic [3:0]        ctl_q
);

   localparam int VEC_MAX = (1 << VEC_W) - 1;

   generate
      if (ESC_BITS > OPC_W) begin : g_chk_esc
         $error("escape pattern wider than opcode byte");
      end
      if (VEC_ERR > VEC_MAX || VEC_NA > VEC_MAX) begin : g_chk_vec
         $error("exception vector does not fit VEC_W");
      end
      if (PRIV_W < 1) begin : g_chk_priv
         $error("privilege width must be at least one bit");
      end
   endgenerate

   cop_ctl_t         ctl;
   logic             accept, esc_go, wait_go;
   logic             is_esc, esc_raise, esc_fwd;
   logic [VEC_W-1:0] esc_vec;
   logic             w_raise, waiting;
   logic [VEC_W-1:0] w_vec;

   cop_ctl_regs #(
      .PRIV_W       (PRIV_W),
      .ET_FROM_PIN  (ET_FROM_PIN),
      .ET_RESET_VAL (ET_RESET_VAL)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .error_n     (error_n),
      .cpl         (cpl),
      .wr_en       (ctl_wr),
      .wr_data     (cop_ctl_t'(ctl_wdata)),
      .task_switch (task_switch),
      .ts_clear    (ts_clear),
      .ctl         (ctl),
      .prot_fault  (prot_fault)
   );

   cop_esc_check #(
      .OPC_W    (OPC_W),
      .ESC_BITS (ESC_BITS),
      .ESC_CODE (ESC_CODE),
      .VEC_W    (VEC_W),
      .VEC_NA   (VEC_NA),
      .VEC_ERR  (VEC_ERR)
   ) i_esc (
      .opcode  (instr_opcode),
      .ctl     (ctl),
      .chk_err (instr_chk_err),
      .error_n (error_n),
      .is_esc  (is_esc),
      .raise   (esc_raise),
      .vec     (esc_vec),
      .fwd     (esc_fwd)
   );

   cop_wait_fsm #(
      .VEC_W   (VEC_W),
      .VEC_NA  (VEC_NA),
      .VEC_ERR (VEC_ERR)
   ) i_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wait_go),
      .ctl     (ctl),
      .busy_n  (busy_n),
      .error_n (error_n),
      .waiting (waiting),
      .raise   (w_raise),
      .vec     (w_vec)
   );

   assign stall   = waiting;
   assign accept  = instr_valid & ~waiting;
   assign esc_go  = accept & ~instr_is_wait & is_esc;
   assign wait_go = accept & instr_is_wait;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cop_fwd    <= 1'b0;
         exc_valid  <= 1'b0;
         exc_vector <= '0;
      end else begin
         cop_fwd    <= esc_go & esc_fwd;
         exc_valid  <= (esc_go & esc_raise) | w_raise;
         exc_vector <= w_raise ? w_vec : esc_vec;
      end
   end

   assign proto32 = ctl.et;
   assign ctl_q   = ctl;

   AST_EM_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (esc_go && ctl.em) |=> (exc_valid && exc_vector == VEC_W'(VEC_NA) && !cop_fwd)); // R2

   AST_NON_ESC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !instr_is_wait && !is_esc) |=> (!exc_valid && !cop_fwd)); // R1

   AST_FWD_XOR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_valid && cop_fwd)); // R5

   AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(esc_go && w_raise)); // R7

endmodule

// File: tb/test_cop_gate.sv
module test_cop_gate;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       instr_valid, instr_is_wait, instr_chk_err;
   logic [7:0] instr_opcode;
   logic       busy_n, error_n, ctl_wr, task_switch, ts_clear;
   logic [3:0] ctl_wdata;
   logic [1:0] cpl;
   logic       cop_fwd, stall, exc_valid, proto32, prot_fault;
   logic [4:0] exc_vector;
   logic [3:0] ctl_q;

   int nvec = 0;
   int nmis = 0;
   logic m_em, m_mp, m_ts, m_et;

   always #2 clk = ~clk;

   cop_gate i_cop_gate (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_opcode(instr_opcode),
      .instr_is_wait(instr_is_wait), .instr_chk_err(instr_chk_err), .busy_n(busy_n),
      .error_n(error_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cpl(cpl),
      .task_switch(task_switch), .ts_clear(ts_clear), .cop_fwd(cop_fwd), .stall(stall),
      .exc_valid(exc_valid), .exc_vector(exc_vector), .proto32(proto32),
      .prot_fault(prot_fault), .ctl_q(ctl_q)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nmis++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] model_ctl();
      return {m_et, m_ts, m_mp, m_em};
   endfunction

   // Expected outcome of an escape: {raise, vector, forward}
   function automatic logic [6:0] exp_esc(input logic [7:0] opc, input logic ce, input logic en);
      if (opc[7:3] != 5'b11011) return 7'b0;
      if (m_em)                 return {1'b1, 5'd7, 1'b0};
      if (m_ts)                 return {1'b1, 5'd7, 1'b0};
      if (ce && !en)            return {1'b1, 5'd16, 1'b0};
      return {1'b0, 5'd0, 1'b1};
   endfunction

   task automatic idle_inputs();
      instr_valid = 0; instr_is_wait = 0; instr_chk_err = 0; instr_opcode = 8'h00;
      ctl_wr = 0; ctl_wdata = 4'h0; cpl = 2'd0; task_switch = 0; ts_clear = 0;
   endtask

   // Apply one cycle of stimulus from a falling edge, return at the next falling edge
   task automatic drive(input logic v, input logic [7:0] opc, input logic w, input logic ce,
                        input logic bn, input logic en, input logic wr, input logic [3:0] wd,
                        input logic [1:0] pl, input logic tsw, input logic tcl);
      instr_valid = v; instr_opcode = opc; instr_is_wait = w; instr_chk_err = ce;
      busy_n = bn; error_n = en; ctl_wr = wr; ctl_wdata = wd; cpl = pl;
      task_switch = tsw; ts_clear = tcl;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic esc_op(input string tag, input logic [7:0] opc, input logic ce, input logic en);
      logic [6:0] e;
      e = exp_esc(opc, ce, en);
      drive(1, opc, 0, ce, 1, en, 0, 4'h0, 2'd0, 0, 0);
      chk({tag, " exc_valid"}, int'(exc_valid), int'(e[6]));
      if (e[6]) chk({tag, " exc_vector"}, int'(exc_vector), int'(e[5:1]));
      chk({tag, " cop_fwd"}, int'(cop_fwd), int'(e[0]));
   endtask

   task automatic write_op(input string tag, input logic [3:0] d, input logic [1:0] pl);
      if (pl == 2'd0) {m_et, m_ts, m_mp, m_em} = d;
      drive(0, 8'h00, 0, 0, 1, 1, 1, d, pl, 0, 0);
      chk({tag, " ctl_q"}, int'(ctl_q), int'(model_ctl()));
      chk({tag, " prot_fault"}, int'(prot_fault), int'(pl != 2'd0));
      chk("R10 proto32", int'(proto32), int'(m_et));
   endtask

   task automatic ts_op(input string tag, input logic tsw, input logic tcl, input logic [1:0] pl);
      if (tcl && pl == 2'd0) m_ts = 1'b0;
      if (tsw) m_ts = 1'b1;
      drive(0, 8'h00, 0, 0, 1, 1, 0, 4'h0, pl, tsw, tcl);
      chk({tag, " ctl_q"}, int'(ctl_q), int'(model_ctl()));
      chk({tag, " prot_fault"}, int'(prot_fault), int'(tcl && pl != 2'd0));
   endtask

   task automatic wait_op(input int nbusy, input logic en);
      if (m_mp && m_ts) begin
         drive(1, 8'h9B, 1, 0, 1, 1, 0, 4'h0, 2'd0, 0, 0);
         chk("R6 wait trap exc_valid", int'(exc_valid), 1);
         chk("R6 wait trap vector", int'(exc_vector), 7);
         chk("R6 wait trap stall", int'(stall), 0);
      end else begin
         drive(1, 8'h9B, 1, 0, 0, 1, 0, 4'h0, 2'd0, 0, 0);
         chk("R7 wait stall rise", int'(stall), 1);
         chk("R6 wait no trap", int'(exc_valid), 0);
         for (int i = 0; i < nbusy; i++) begin
            drive(1, 8'hD9, 0, 0, 0, 0, 0, 4'h0, 2'd0, 0, 0);
            chk("R7 stall held", int'(stall), 1);
            chk("R7 strobe ignored fwd", int'(cop_fwd), 0);
            chk("R7 strobe ignored exc", int'(exc_valid), 0);
         end
         drive(0, 8'h00, 0, 0, 1, en, 0, 4'h0, 2'd0, 0, 0);
         chk("R7 stall release", int'(stall), 0);
         chk("R7 error after busy", int'(exc_valid), int'(!en));
         if (!en) chk("R7 error vector", int'(exc_vector), 16);
      end
   endtask

   task automatic do_reset(input logic en);
      idle_inputs();
      busy_n = 1; error_n = en; rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_em = 0; m_mp = 0; m_ts = 0; m_et = en;
      chk("R10 reset ctl_q", int'(ctl_q), int'(model_ctl()));
      chk("R10 reset proto32", int'(proto32), int'(en));
      chk("R10 reset stall", int'(stall), 0);
      chk("R10 reset exc", int'(exc_valid), 0);
      chk("R10 reset fwd", int'(cop_fwd), 0);
   endtask

   initial begin
      #(200000 * 4);
      nmis++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

   initial begin
      logic [6:0] e;
      void'($urandom(32'd1987));
      @(negedge clk);
      do_reset(1'b1);

      // Directed corner cases
      esc_op("R5 clean escape", 8'hD9, 0, 1);
      drive(0, 8'h00, 0, 0, 1, 1, 0, 4'h0, 2'd0, 0, 0);
      chk("R5 forward one cycle", int'(cop_fwd), 0);
      esc_op("R1 non-escape D0", 8'hD0, 0, 1);
      esc_op("R1 non-escape E0", 8'hE0, 1, 0);
      esc_op("R4 unflagged ignores error", 8'hDD, 0, 0);
      esc_op("R4 flagged error", 8'hDD, 1, 0);
      ts_op("R8 task switch", 1, 0, 2'd0);
      esc_op("R3 ts trap", 8'hD8, 1, 0);
      wait_op(2, 0);
      wait_op(0, 1);
      write_op("R8 priv write", 4'b1110, 2'd0);
      wait_op(1, 1);
      write_op("R9 user write", 4'b0001, 2'd3);
      ts_op("R9 user clear", 0, 1, 2'd1);
      write_op("R8 em set", 4'b1101, 2'd0);
      esc_op("R2 em over ts", 8'hDF, 1, 0);
      ts_op("R8 switch beats clear", 1, 1, 2'd0);
      ts_op("R8 priv clear", 0, 1, 2'd0);
      write_op("R8 all clear", 4'b0000, 2'd0);

      // Same-cycle: escape with a write that sets EM
      drive(1, 8'hDA, 0, 0, 1, 1, 1, 4'b0001, 2'd0, 0, 0);
      chk("R11 old em used fwd", int'(cop_fwd), 1);
      chk("R11 old em used exc", int'(exc_valid), 0);
      m_em = 1;
      chk("R11 write landed", int'(ctl_q), int'(model_ctl()));
      write_op("R8 clear em", 4'b0000, 2'd0);
      // Same-cycle: escape with a task switch
      drive(1, 8'hDB, 0, 0, 1, 1, 0, 4'h0, 2'd0, 1, 0);
      chk("R11 old ts used fwd", int'(cop_fwd), 1);
      m_ts = 1;
      chk("R11 ts landed", int'(ctl_q), int'(model_ctl()));

      // Constrained random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         op = int'($urandom % 7);
         case (op)
            0, 1: begin
               logic [7:0] opc;
               opc = 8'($urandom);
               if ($urandom % 4 != 0) opc[7:3] = 5'b11011;
               esc_op("R1 R4 random escape", opc, 1'($urandom), 1'($urandom));
            end
            2: wait_op(int'($urandom % 4), 1'($urandom));
            3: write_op("R8 random write", 4'($urandom), 2'd0);
            4: write_op("R9 random user write", 4'($urandom), 2'(($urandom % 3) + 1));
            5: ts_op("R8 random switch", 1, 1'($urandom), 2'($urandom));
            default: ts_op("R8 random clear", 0, 1, 2'($urandom));
         endcase
      end

      do_reset(1'b0);
      e = exp_esc(8'hDE, 0, 1);
      esc_op("R10 escape after reset", 8'hDE, 0, 1);
      chk("R10 model forward", int'(e[0]), 1);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

endmodule